// File: doc/BRIEF.md
# Lane Deskew Marker Generator

This transmit-side block sits between a 160-bit MAC data path and ten per-lane 64B/66B encoders. In every cycle that carries frame data it cuts the input word into ten 16-bit lane slices and passes them on unchanged. In inter-frame gaps it fills the lanes with deskew markers. Each marker is a 64-bit block of eight control characters, and its first five characters spell a 5-bit rolling phase index in idle and sync characters. A receiver compares the phase seen on each lane and from the difference works out the inter-lane skew.

A marker takes four consecutive cycles per lane, 16 bits per cycle, and all ten lanes carry the same marker beat in the same cycle. The upstream framer reports, with every gap cycle, how many gap cycles remain, counting the current one. A marker starts only when at least four gap cycles remain. A shorter gap is filled with plain idles. The phase index steps by one after each completed marker and keeps its value across frames, so the sequence carries on from one gap into the next. Outputs are registered, one cycle after the inputs.

Top module: `deskew_marker_gen`

## Requirements
- R1: When `gap_i` is 0 and no marker is in progress, lane k of `lane_data_o` one cycle later equals `data_i[16k+15:16k]`, and all `lane_ctrl_o` bits are 0.
- R2: While reset is low, and after its release, every output byte is the idle character 0x07, every `lane_ctrl_o` bit is 1, and the phase index is 0, so the first marker after reset is phase 0.
- R3: Marker beat b (0..3) places character C(2b) in bits [7:0] of each lane slice and C(2b+1) in bits [15:8]. For j < 5, Cj is the sync character 0xBC if bit (4-j) of the phase is 1, otherwise the idle character 0x07. C5, C6 and C7 are 0x07.
- R4: In every marker or idle cycle, all ten lane slices are identical.
- R5: A marker starts only when `gap_i` is 1, `gap_left_i` is at least 4 and no marker is in progress. Once started, it runs its four beats in consecutive cycles, whatever `gap_i`, `gap_left_i` and `data_i` do.
- R6: The phase index increases by one, modulo 32, after the fourth beat of each marker. It stays unchanged across data and idle cycles and wraps from 31 to 0.
- R7: A gap cycle with no marker in progress and `gap_left_i` below 4 outputs 0x07 in every byte with all control bits at 1, and leaves the phase unchanged.
- R8: If a gap still has at least 4 cycles remaining when a marker ends, the next marker starts in the following cycle with no idle cycle in between.
- R9: `lane_ctrl_o` bit 2k flags bits [7:0] of lane k and bit 2k+1 flags bits [15:8]. A flag is 1 when that byte is a control character (idle or sync) and 0 for frame data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 160 | MAC data word, 16 bits per lane |
| gap_i | input | 1 | Current cycle belongs to an inter-frame gap |
| gap_left_i | input | 8 | Gap cycles remaining, counting the current one (valid with gap_i) |
| lane_data_o | output | 160 | Ten 16-bit lane slices, lane k at [16k+15:16k] |
| lane_ctrl_o | output | 20 | Per-byte control flags, two per lane |

## Verification
The bench sends gaps just too short for a marker (three cycles left) and gaps just long enough (exactly four). A design with the threshold off by one would either clip a marker at the end of the gap or leave a usable gap with idles only. Frame data is raised in the middle of a marker, and `gap_left_i` runs down to 1 while a marker is under way. A design that let either input interrupt the marker would output data or idles where beats 1 to 3 belong. The bench also runs the phase through 31 and back to 0, and applies reset in the middle of a marker. These catch a counter that saturates instead of wrapping, and phase or beat state that survives reset.

// File: rtl/dmg_pkg.sv
package dmg_pkg;
  localparam int CHAR_W = 8;
  localparam logic [CHAR_W-1:0] IDLE_CHAR = 8'h07;
  localparam logic [CHAR_W-1:0] SYNC_CHAR = 8'hBC;

  typedef enum logic [1:0] {
    MODE_DATA = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_MARK = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/dmg_sequencer.sv
module dmg_sequencer
  import dmg_pkg::*;
#(
  parameter int PHASE_W      = 5,
  parameter int MARKER_BEATS = 4,
  parameter int GAP_W        = 8,
  localparam int BEAT_W      = $clog2(MARKER_BEATS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               gap_i,
  input  logic [GAP_W-1:0]   gap_left_i,
  output lane_mode_e         mode_o,
  output logic [BEAT_W-1:0]  cur_beat_o,
  output logic [BEAT_W-1:0]  beat_q_o,
  output logic [PHASE_W-1:0] phase_q_o
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(MARKER_BEATS - 1);

  logic [BEAT_W-1:0]  beat_q, beat_d, cur_beat;
  logic [PHASE_W-1:0] phase_q, phase_d;
  lane_mode_e         mode;

  always_comb begin
    cur_beat = '0;
    if (beat_q != '0) begin
      mode     = MODE_MARK;
      cur_beat = beat_q;
    end else if (gap_i && (gap_left_i >= GAP_W'(MARKER_BEATS))) begin
      mode = MODE_MARK;
    end else if (gap_i) begin
      mode = MODE_IDLE;
    end else begin
      mode = MODE_DATA;
    end
  end

  always_comb begin
    beat_d  = '0;
    phase_d = phase_q;
    if (mode == MODE_MARK) begin
      if (cur_beat == LAST_BEAT) begin
        phase_d = phase_q + PHASE_W'(1);
      end else begin
        beat_d = cur_beat + BEAT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q  <= '0;
      phase_q <= '0;
    end else begin
      beat_q  <= beat_d;
      phase_q <= phase_d;
    end
  end

  assign mode_o     = mode;
  assign cur_beat_o = cur_beat;
  assign beat_q_o   = beat_q;
  assign phase_q_o  = phase_q;
endmodule

// File: rtl/dmg_marker_slice.sv
module dmg_marker_slice
  import dmg_pkg::*;
#(
  parameter int PHASE_W      = 5,
  parameter int MARKER_BEATS = 4,
  parameter int LANE_W       = 16,
  localparam int BEAT_W      = $clog2(MARKER_BEATS),
  localparam int CPL         = LANE_W / CHAR_W,
  localparam int MCHARS      = MARKER_BEATS * CPL
) (
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [BEAT_W-1:0]  beat_i,
  output logic [LANE_W-1:0]  slice_o
);
  logic [MCHARS*CHAR_W-1:0] marker;

  // Leading characters carry the phase MSB first; the rest are idle.
  for (genvar c = 0; c < MCHARS; c++) begin : g_char
    if (c < PHASE_W) begin : g_code
      assign marker[c*CHAR_W +: CHAR_W] = phase_i[PHASE_W-1-c] ? SYNC_CHAR : IDLE_CHAR;
    end else begin : g_fill
      assign marker[c*CHAR_W +: CHAR_W] = IDLE_CHAR;
    end
  end

  assign slice_o = marker[beat_i*LANE_W +: LANE_W];
endmodule

// File: rtl/dmg_lane_out.sv
module dmg_lane_out
  import dmg_pkg::*;
#(
  parameter int LANE_W = 16,
  localparam int CPL   = LANE_W / CHAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  lane_mode_e        mode_i,
  input  logic [LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0] marker_i,
  output logic [LANE_W-1:0] slice_o,
  output logic [CPL-1:0]    ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slice_o <= {CPL{IDLE_CHAR}};
      ctrl_o  <= '1;
    end else begin
      unique case (mode_i)
        MODE_DATA: begin
          slice_o <= data_i;
          ctrl_o  <= '0;
        end
        MODE_MARK: begin
          slice_o <= marker_i;
          ctrl_o  <= '1;
        end
        default: begin
          slice_o <= {CPL{IDLE_CHAR}};
          ctrl_o  <= '1;
        end
      endcase
    end
  end
endmodule

// File: rtl/deskew_marker_gen.sv
module deskew_marker_gen
  import dmg_pkg::*;
#(
  parameter int NUM_LANES    = 10,
  parameter int LANE_W       = 16,
  parameter int GAP_W        = 8,
  parameter int MARKER_BEATS = 4,
  parameter int PHASE_W      = 5,
  localparam int WORD_W      = NUM_LANES * LANE_W,
  localparam int CPL         = LANE_W / CHAR_W,
  localparam int BEAT_W      = $clog2(MARKER_BEATS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [WORD_W-1:0]        data_i,
  input  logic                     gap_i,
  input  logic [GAP_W-1:0]         gap_left_i,
  output logic [WORD_W-1:0]        lane_data_o,
  output logic [NUM_LANES*CPL-1:0] lane_ctrl_o
);
  lane_mode_e         mode;
  logic [BEAT_W-1:0]  cur_beat, beat_q;
  logic [PHASE_W-1:0] phase_q;
  logic [LANE_W-1:0]  marker_slice;

  dmg_sequencer #(
    .PHASE_W(PHASE_W), .MARKER_BEATS(MARKER_BEATS), .GAP_W(GAP_W)
  ) u_seq (
    .clk_i, .rst_ni, .gap_i, .gap_left_i,
    .mode_o(mode), .cur_beat_o(cur_beat), .beat_q_o(beat_q), .phase_q_o(phase_q)
  );

  dmg_marker_slice #(
    .PHASE_W(PHASE_W), .MARKER_BEATS(MARKER_BEATS), .LANE_W(LANE_W)
  ) u_mark (
    .phase_i(phase_q), .beat_i(cur_beat), .slice_o(marker_slice)
  );

  // One shared marker slice feeds every lane so all lanes stay aligned.
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    dmg_lane_out #(.LANE_W(LANE_W)) u_lane (
      .clk_i, .rst_ni,
      .mode_i(mode),
      .data_i(data_i[k*LANE_W +: LANE_W]),
      .marker_i(marker_slice),
      .slice_o(lane_data_o[k*LANE_W +: LANE_W]),
      .ctrl_o(lane_ctrl_o[k*CPL +: CPL])
    );
  end
endmodule

// File: rtl/deskew_marker_gen_chk.sv
module deskew_marker_gen_chk
  import dmg_pkg::*;
#(
  parameter int NUM_LANES    = 10,
  parameter int LANE_W       = 16,
  parameter int GAP_W        = 8,
  parameter int MARKER_BEATS = 4,
  parameter int PHASE_W      = 5,
  localparam int WORD_W      = NUM_LANES * LANE_W,
  localparam int CPL         = LANE_W / CHAR_W,
  localparam int BEAT_W      = $clog2(MARKER_BEATS)
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [WORD_W-1:0]        data_i,
  input logic                     gap_i,
  input logic [GAP_W-1:0]         gap_left_i,
  input logic [WORD_W-1:0]        lane_data_o,
  input logic [NUM_LANES*CPL-1:0] lane_ctrl_o,
  input logic [BEAT_W-1:0]        beat_q,
  input logic [PHASE_W-1:0]       phase_q
);
  a_r1_data_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gap_i && beat_q == '0) |=> (lane_data_o == $past(data_i) && lane_ctrl_o == '0));

  a_r5_marker_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_q != '0) |=> (&lane_ctrl_o));

  a_r6_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != $past(phase_q)) |->
      (phase_q == $past(phase_q) + PHASE_W'(1) && $past(beat_q) == BEAT_W'(MARKER_BEATS - 1)));

  a_r7_short_gap_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_i && beat_q == '0 && gap_left_i < GAP_W'(MARKER_BEATS)) |=>
      (lane_data_o == {(NUM_LANES*CPL){IDLE_CHAR}} && (&lane_ctrl_o)));

  a_r7_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_q == '0 && !(gap_i && gap_left_i >= GAP_W'(MARKER_BEATS))) |=> $stable(phase_q));

  for (genvar k = 1; k < NUM_LANES; k++) begin : g_eq
    a_r4_lanes_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&lane_ctrl_o) |-> (lane_data_o[k*LANE_W +: LANE_W] == lane_data_o[LANE_W-1:0]));
  end
endmodule

bind deskew_marker_gen deskew_marker_gen_chk #(
  .NUM_LANES(NUM_LANES), .LANE_W(LANE_W), .GAP_W(GAP_W),
  .MARKER_BEATS(MARKER_BEATS), .PHASE_W(PHASE_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_i(data_i), .gap_i(gap_i),
  .gap_left_i(gap_left_i), .lane_data_o(lane_data_o), .lane_ctrl_o(lane_ctrl_o),
  .beat_q(beat_q), .phase_q(phase_q)
);

// File: tb/sim_deskew_marker_gen.sv
`timescale 1ns/1ps
module sim_deskew_marker_gen;
  localparam int NL = 10;
  localparam int WW = 160;
  localparam int CW = 20;
  localparam int K_DATA = 0, K_IDLE = 1, K_MARK = 2;

  typedef struct packed {
    logic       gap;
    logic [7:0] left;
    logic [7:0] seed;
    logic [1:0] kind;
    logic [4:0] phase;
    logic [1:0] beat;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'd0, 8'h11, 2'd0, 5'd0, 2'd0},  // R1 data
    '{1'b0, 8'd0, 8'h22, 2'd0, 5'd0, 2'd0},  // R1 data
    '{1'b1, 8'd2, 8'h00, 2'd1, 5'd0, 2'd0},  // R7 short gap
    '{1'b1, 8'd1, 8'h00, 2'd1, 5'd0, 2'd0},  // R7
    '{1'b0, 8'd0, 8'h33, 2'd0, 5'd0, 2'd0},  // R1
    '{1'b1, 8'd8, 8'h00, 2'd2, 5'd0, 2'd0},  // R3 S0
    '{1'b1, 8'd7, 8'h00, 2'd2, 5'd0, 2'd1},
    '{1'b1, 8'd6, 8'h00, 2'd2, 5'd0, 2'd2},
    '{1'b1, 8'd5, 8'h00, 2'd2, 5'd0, 2'd3},
    '{1'b1, 8'd4, 8'h00, 2'd2, 5'd1, 2'd0},  // R8 back to back, R6 step
    '{1'b1, 8'd3, 8'h00, 2'd2, 5'd1, 2'd1},  // R5 gap_left ignored in marker
    '{1'b1, 8'd2, 8'h00, 2'd2, 5'd1, 2'd2},
    '{1'b1, 8'd1, 8'h00, 2'd2, 5'd1, 2'd3},
    '{1'b0, 8'd0, 8'h44, 2'd0, 5'd0, 2'd0},  // R1
    '{1'b1, 8'd5, 8'h00, 2'd2, 5'd2, 2'd0},  // R6 phase held over data
    '{1'b0, 8'd0, 8'h55, 2'd2, 5'd2, 2'd1},  // R5 data overridden
    '{1'b0, 8'd0, 8'h66, 2'd2, 5'd2, 2'd2},  // R5
    '{1'b0, 8'd0, 8'h77, 2'd2, 5'd2, 2'd3},  // R5
    '{1'b0, 8'd0, 8'h88, 2'd0, 5'd0, 2'd0},  // R1
    '{1'b1, 8'd3, 8'h00, 2'd1, 5'd0, 2'd0},  // R7 three left: idle
    '{1'b1, 8'd4, 8'h00, 2'd2, 5'd3, 2'd0},  // R5 exactly four: marker
    '{1'b1, 8'd3, 8'h00, 2'd2, 5'd3, 2'd1},
    '{1'b1, 8'd2, 8'h00, 2'd2, 5'd3, 2'd2},
    '{1'b1, 8'd1, 8'h00, 2'd2, 5'd3, 2'd3},
    '{1'b0, 8'd0, 8'h99, 2'd0, 5'd0, 2'd0}   // R1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [WW-1:0] data = '0;
  logic          gap = 1'b0;
  logic [7:0]    left = '0;
  logic [WW-1:0] lane_data;
  logic [CW-1:0] lane_ctrl;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  deskew_marker_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .gap_i(gap),
    .gap_left_i(left), .lane_data_o(lane_data), .lane_ctrl_o(lane_ctrl)
  );

  function automatic logic [WW-1:0] mk_data(input logic [7:0] seed);
    logic [WW-1:0] w;
    for (int k = 0; k < NL; k++) w[k*16 +: 16] = {seed, 4'hA, 4'(k)};
    return w;
  endfunction

  function automatic logic [15:0] mk_mark(input logic [4:0] ph, input logic [1:0] bt);
    logic [15:0] s;
    for (int j = 0; j < 2; j++) begin
      int c;
      c = 2 * int'(bt) + j;
      s[j*8 +: 8] = (c < 5 && ph[4-c]) ? 8'hBC : 8'h07;
    end
    return s;
  endfunction

  task automatic compare(input int kind, input logic [4:0] ph, input logic [1:0] bt,
                         input logic [7:0] seed, input string tag);
    logic [WW-1:0] ed;
    logic [CW-1:0] ec;
    if (kind == K_DATA) begin
      ed = mk_data(seed); ec = '0;
    end else if (kind == K_IDLE) begin
      ed = {(NL*2){8'h07}}; ec = '1;
    end else begin
      ed = {NL{mk_mark(ph, bt)}}; ec = '1;
    end
    n_chk++;
    if (lane_data !== ed || lane_ctrl !== ec) begin
      n_fail++;
      $display("FAIL %s: data=%h ctrl=%h expected data=%h ctrl=%h", tag, lane_data, lane_ctrl, ed, ec);
    end
  endtask

  task automatic step(input logic g, input logic [7:0] l, input logic [7:0] s,
                      input int kind, input logic [4:0] ph, input logic [1:0] bt, input string tag);
    @(negedge clk);
    gap = g; left = l; data = mk_data(s);
    @(posedge clk);
    #1;
    compare(kind, ph, bt, s, tag);
  endtask

  initial begin
    #(5ns * 20000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare(K_IDLE, 5'd0, 2'd0, 8'h00, "R2 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table: R1 R3 R4 R5 R6 R7 R8 R9 are covered by whole-word compares.
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = (VEC[i].kind == 2'd0) ? "R1 R9 data" :
            (VEC[i].kind == 2'd1) ? "R7 R4 idle" : "R3 R4 R5 R8 marker";
      step(VEC[i].gap, VEC[i].left, VEC[i].seed, int'(VEC[i].kind),
           VEC[i].phase, VEC[i].beat, tag);
    end

    // R6: run phases 4..31 back to back, then wrap to 0.
    for (int p = 4; p < 32; p++) begin
      for (int b = 0; b < 4; b++)
        step(1'b1, 8'd200, 8'h00, K_MARK, 5'(p), 2'(b), "R6 phase run");
    end
    for (int b = 0; b < 4; b++)
      step(1'b1, 8'd200, 8'h00, K_MARK, 5'd0, 2'(b), "R6 wrap to zero");
    step(1'b1, 8'd200, 8'h00, K_MARK, 5'd1, 2'd0, "R6 after wrap");

    // R2: reset in the middle of a marker.
    @(negedge clk);
    rst_n = 1'b0;
    gap = 1'b0;
    #1;
    compare(K_IDLE, 5'd0, 2'd0, 8'h00, "R2 reset mid marker");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 8'd9, 8'h00, K_MARK, 5'd0, 2'd0, "R2 phase restarts at S0");
    step(1'b1, 8'd8, 8'h00, K_MARK, 5'd0, 2'd1, "R2 beat restarts");
    step(1'b0, 8'd0, 8'h5A, K_MARK, 5'd0, 2'd2, "R5 marker completes");
    step(1'b0, 8'd0, 8'h5B, K_MARK, 5'd0, 2'd3, "R5 marker completes");
    step(1'b0, 8'd0, 8'h5C, K_DATA, 5'd0, 2'd0, "R1 data resumes");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule